// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block collects up to thirty-two interrupt request lines from on-chip peripherals and turns them into two processor interrupt lines, one for normal and one for critical service. Each line can be configured to be edge or level sensitive, and the active edge or level can be either polarity. Every request first passes through a two-flop synchronizer. A detected event then sets a bit in a sticky pending register. Software removes that bit by writing a one to it. A per-source enable bit gates the pending bits onto the outputs, and a per-source select bit routes each enabled source to either the normal or the critical output.

Software reaches the registers through a word-addressed port that takes one access per cycle. The port never stalls, so it has no ready signal. Read data appears on the cycle after the request and is held until the next read. A pending-and-enabled view of the sources and a priority-encoded source number can be read from the same port. One controller can be cascaded into another by wiring its interrupt output to one of the other controller's request lines.

Source number n occupies register bit 31−n, so source 0 is the most significant bit and has the highest priority. A level-sensitive pending bit cannot be cleared while its input is still active. Software must therefore clear a level source after the device has dropped its request, and clear an edge source before servicing it.

Top module: `intc_top`

## Requirements
- R1: Register offsets are: pending 0x0, enable 0x2, critical select 0x3, polarity 0x4, trigger 0x5, masked pending 0x6, vector 0x7. Source n is held in bit 31−n of every per-source register, so source 0 is bit 31.
- R2: After reset the enable, critical select, polarity and trigger registers read zero and both interrupt outputs are low.
- R3: A trigger bit of 1 selects edge mode. In edge mode, a rising edge sets the pending bit when polarity is 1, and a falling edge sets it when polarity is 0. The bit stays set until software clears it, whatever the enable bit is.
- R4: A trigger bit of 0 selects level mode. In level mode the pending bit is set on every cycle in which the synchronized input equals the polarity bit, so a clear has no effect while the input stays active, even when the source is disabled. Once the input goes inactive, the bit stays set until it is cleared.
- R5: Writing a word to offset 0x0 clears each pending bit written as one and leaves the bits written as zero unchanged. A new event in the same cycle as its clear wins, and the bit stays set.
- R6: Offset 0x6 reads the bitwise AND of the pending and enable registers.
- R7: `irq_norm_o` is high when some pending and enabled source has its critical select bit at 0. `irq_crit_o` is high when some pending and enabled source has its critical select bit at 1.
- R8: Offset 0x7 reads, in bits 5:0, the lowest-numbered source that is pending and enabled. When no such source exists it reads 32.
- R9: Writes to offsets 0x6 and 0x7 and to unused offsets change nothing. Reads of unused offsets return zero.
- R10: A register write takes effect at the next clock edge. Read data is registered and is valid on the cycle after the request. An input change sets its pending bit at the third clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Request lines, bit n is source n (asynchronous) |
| req_i | input | 1 | Register access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
The assertions assume that the request, write-enable, address and data inputs are stable around each rising edge. They also assume that the request lines may change at any time, because the synchronizer absorbs them. The bench therefore changes every input on the falling edge. It lets each input change settle for five cycles before comparing pending bits, and it keeps register accesses to one per cycle. This way the bench model can treat each input change as a single transition seen by the edge detector. The bench also schedules one event so that it lands in exactly the cycle of its own clear, to exercise the rule that a new event beats a clear.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int OFS_W = 4;

  // Register offsets; software decodes these so their values are fixed.
  typedef enum logic [OFS_W-1:0] {
    SEL_PEND  = 4'h0,
    SEL_ENA   = 4'h2,
    SEL_CRIT  = 4'h3,
    SEL_POL   = 4'h4,
    SEL_TRIG  = 4'h5,
    SEL_MPEND = 4'h6,
    SEL_VEC   = 4'h7
  } reg_sel_e;

endpackage

// File: rtl/intc_src_front.sv
// Synchronizes each request line and produces level and edge strobes,
// reordered so that source n lands in bit NUM_SRC-1-n.
module intc_src_front #(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  output logic [NUM_SRC-1:0] lvl_o,
  output logic [NUM_SRC-1:0] rise_o,
  output logic [NUM_SRC-1:0] fall_o
);

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int RB = NUM_SRC - 1 - n;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], irq_src_i[n]};
        prev_q <= sync_q[SYNC_STAGES-1];
      end
    end

    assign lvl_o[RB]  = sync_q[SYNC_STAGES-1];
    assign rise_o[RB] = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign fall_o[RB] = ~sync_q[SYNC_STAGES-1] & prev_q;
  end

endmodule

// File: rtl/intc_pend_reg.sv
// Sticky pending bits: set by the selected event, cleared by write-one.
module intc_pend_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] fall_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] edge_hit;
  logic [NUM_SRC-1:0] lvl_hit;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] pend_q;

  always_comb begin
    edge_hit = (pol_i & rise_i) | (~pol_i & fall_i);
    lvl_hit  = ~(lvl_i ^ pol_i);
    set_vec  = (trig_i & edge_hit) | (~trig_i & lvl_hit);
  end

  // A set in the same cycle as a clear keeps the bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_vec;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/intc_prio.sv
// Lowest source number wins; source 0 sits in the top bit.
module intc_prio #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 6
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic [VEC_W-1:0]   vec_o
);

  always_comb begin
    vec_o = VEC_W'(NUM_SRC);
    for (int b = 0; b < NUM_SRC; b++) begin
      if (req_i[b]) vec_o = VEC_W'(NUM_SRC - 1 - b);
    end
  end

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               irq_norm_o,
  output logic               irq_crit_o
);

  localparam int VEC_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] lvl, rise, fall;
  logic [NUM_SRC-1:0] pend_q, ena_q, crit_q, pol_q, trig_q;
  logic [NUM_SRC-1:0] mpend, clr_mask;
  logic [VEC_W-1:0]   vec;
  logic               wr, rd;
  logic [NUM_SRC-1:0] rd_mux;
  logic [NUM_SRC-1:0] rdata_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  intc_src_front #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign clr_mask = (wr && addr_i == ADDR_W'(SEL_PEND)) ? wdata_i : '0;

  intc_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_q), .pol_i(pol_q),
    .lvl_i(lvl), .rise_i(rise), .fall_i(fall), .clr_i(clr_mask),
    .pend_o(pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (wr) begin
      if (addr_i == ADDR_W'(SEL_ENA))  ena_q  <= wdata_i;
      if (addr_i == ADDR_W'(SEL_CRIT)) crit_q <= wdata_i;
      if (addr_i == ADDR_W'(SEL_POL))  pol_q  <= wdata_i;
      if (addr_i == ADDR_W'(SEL_TRIG)) trig_q <= wdata_i;
    end
  end

  assign mpend = pend_q & ena_q;

  intc_prio #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_prio (
    .req_i(mpend), .vec_o(vec)
  );

  always_comb begin
    case (addr_i)
      ADDR_W'(SEL_PEND):  rd_mux = pend_q;
      ADDR_W'(SEL_ENA):   rd_mux = ena_q;
      ADDR_W'(SEL_CRIT):  rd_mux = crit_q;
      ADDR_W'(SEL_POL):   rd_mux = pol_q;
      ADDR_W'(SEL_TRIG):  rd_mux = trig_q;
      ADDR_W'(SEL_MPEND): rd_mux = mpend;
      ADDR_W'(SEL_VEC):   rd_mux = NUM_SRC'(vec);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata_o    = rdata_q;
  assign irq_norm_o = |(mpend & ~crit_q);
  assign irq_crit_o = |(mpend & crit_q);

endmodule

// File: rtl/intc_top_chk.sv
module intc_top_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic [NUM_SRC-1:0] rdata_o,
  input logic               irq_norm_o,
  input logic               irq_crit_o,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] ena_q,
  input logic [NUM_SRC-1:0] crit_q,
  input logic [NUM_SRC-1:0] pol_q,
  input logic [NUM_SRC-1:0] trig_q,
  input logic [NUM_SRC-1:0] lvl
);

  logic clr_wr, ena_wr, ena_rd;
  assign clr_wr = req_i && we_i && addr_i == ADDR_W'(SEL_PEND);
  assign ena_wr = req_i && we_i && addr_i == ADDR_W'(SEL_ENA);
  assign ena_rd = req_i && !we_i && addr_i == ADDR_W'(SEL_ENA);

  // R5: pending bits only fall through a clear write
  assert_pend_no_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((~pend_q & $past(pend_q)) == '0));

  // R1: a write to the enable offset loads the word
  assert_ena_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ena_wr |=> (ena_q == $past(wdata_i)));

  // R9: enable changes only through its own offset
  assert_ena_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_wr |=> $stable(ena_q));

  // R4: an active level source is pending one cycle later
  assert_level_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(trig_q) & ~($past(lvl) ^ $past(pol_q)) & ~pend_q) == '0));

  // R7: critical output needs an enabled critical source
  assert_crit_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit_o |-> ((crit_q & ena_q) != '0));

  // R7: all disabled means both outputs are quiet
  assert_quiet_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> (!irq_norm_o && !irq_crit_o));

  // R10: read data arrives one cycle after the request
  assert_rd_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ena_rd |=> (rdata_o == $past(ena_q)));

endmodule

bind intc_top intc_top_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_norm_o(irq_norm_o),
  .irq_crit_o(irq_crit_o), .pend_q(pend_q), .ena_q(ena_q), .crit_q(crit_q),
  .pol_q(pol_q), .trig_q(trig_q), .lvl(lvl)
);

// File: tb/intc_top_test.sv
module intc_top_test;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_src = '0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq_norm, irq_crit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model, register bit order
  logic [N-1:0] e_pend = '0, e_ena = '0, e_crit = '0, e_pol = '0, e_trig = '0;
  logic [N-1:0] cur = '0;

  always #5 clk = ~clk;

  intc_top uut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_norm_o(irq_norm), .irq_crit_o(irq_crit)
  );

  function automatic logic [N-1:0] to_reg(logic [N-1:0] s);
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) r[N-1-n] = s[n];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_vec(logic [N-1:0] m);
    for (int n = 0; n < N; n++) if (m[N-1-n]) return N'(n);
    return N'(N);
  endfunction

  task automatic chk(logic [N-1:0] got, logic [N-1:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic lvl_fill();
    e_pend |= ~e_trig & ~(to_reg(cur) ^ e_pol);
  endtask

  task automatic settle(int k);
    repeat (k) @(negedge clk);
  endtask

  // all access tasks start and end on a falling edge
  task automatic reg_wr(logic [3:0] a, logic [N-1:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(logic [3:0] a, output logic [N-1:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic cfg_wr(logic [3:0] a, logic [N-1:0] d);
    reg_wr(a, d);
    case (a)
      4'h0: e_pend &= ~d;
      4'h2: e_ena = d;
      4'h3: e_crit = d;
      4'h4: e_pol = d;
      4'h5: e_trig = d;
      default: ;
    endcase
    lvl_fill();
  endtask

  task automatic model_src(logic [N-1:0] nw);
    logic [N-1:0] o, nr;
    o = to_reg(cur); nr = to_reg(nw);
    e_pend |= e_trig & ((e_pol & ~o & nr) | (~e_pol & o & ~nr));
    cur = nw;
    lvl_fill();
  endtask

  task automatic drive_src(logic [N-1:0] nw);
    irq_src = nw;
    model_src(nw);
    settle(5);
  endtask

  task automatic check_all(string ctx);
    logic [N-1:0] d;
    settle(3);
    reg_rd(4'h0, d); chk(d, e_pend, {"R3/R4 pending ", ctx});
    reg_rd(4'h6, d); chk(d, e_pend & e_ena, {"R6 masked ", ctx});
    reg_rd(4'h7, d); chk(d, exp_vec(e_pend & e_ena), {"R8 vector ", ctx});
    chk(N'(irq_norm), N'(|(e_pend & e_ena & ~e_crit)), {"R7 normal out ", ctx});
    chk(N'(irq_crit), N'(|(e_pend & e_ena & e_crit)), {"R7 critical out ", ctx});
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    void'($urandom(32'h5EED_0042));
    settle(3);
    rst_n = 1'b1;
    @(negedge clk);
    lvl_fill();

    // R2: reset state
    reg_rd(4'h2, d); chk(d, '0, "R2 enable after reset");
    reg_rd(4'h3, d); chk(d, '0, "R2 critical after reset");
    reg_rd(4'h4, d); chk(d, '0, "R2 polarity after reset");
    reg_rd(4'h5, d); chk(d, '0, "R2 trigger after reset");
    chk(N'({irq_norm, irq_crit}), '0, "R2 outputs after reset");
    settle(2);
    // low inputs are active for level-low sources
    reg_rd(4'h0, d); chk(d, '1, "R4 level-low all pending");

    // R3 + R1: edge rising on source 0 shows in bit 31, held while disabled
    cfg_wr(4'h5, '1);
    cfg_wr(4'h4, '1);
    cfg_wr(4'h0, '1);
    reg_rd(4'h0, d); chk(d, '0, "R5 clear all edge sources");
    drive_src(32'h0000_0001);
    reg_rd(4'h0, d); chk(d, 32'h8000_0000, "R1 R3 source 0 maps to bit 31");
    drive_src(32'h0000_0000);
    reg_rd(4'h0, d); chk(d, 32'h8000_0000, "R3 edge held while disabled");
    reg_rd(4'h7, d); chk(d, 32'd32, "R8 vector none when disabled");
    cfg_wr(4'h2, 32'h8000_0000);
    check_all("edge src0 enabled");
    reg_rd(4'h7, d); chk(d, 32'd0, "R8 vector is source 0");
    cfg_wr(4'h3, 32'h8000_0000);
    check_all("src0 critical");
    chk(N'(irq_crit), 32'd1, "R7 critical output raised");

    // R9: read-only and unused offsets
    reg_wr(4'h6, '0); reg_wr(4'h7, '1); reg_wr(4'h1, '1); reg_wr(4'h9, '1);
    reg_rd(4'h2, d); chk(d, 32'h8000_0000, "R9 enable untouched");
    reg_rd(4'h6, d); chk(d, 32'h8000_0000, "R9 masked untouched");
    reg_rd(4'h1, d); chk(d, '0, "R9 unused offset reads zero");
    reg_rd(4'h9, d); chk(d, '0, "R9 unused offset 9 reads zero");

    // R4: level-high source 3 (bit 28) cannot be cleared while active
    cfg_wr(4'h0, '1);
    cfg_wr(4'h5, ~32'h1000_0000);
    drive_src(32'h0000_0008);
    cfg_wr(4'h0, '1);
    settle(2);
    reg_rd(4'h0, d); chk(d, 32'h1000_0000, "R4 clear overridden while active");
    drive_src(32'h0000_0000);
    reg_rd(4'h0, d); chk(d, 32'h1000_0000, "R4 level latched after release");
    cfg_wr(4'h0, 32'h1000_0000);
    settle(2);
    reg_rd(4'h0, d); chk(d, '0, "R4 cleared after release");

    // R5 + R10: rising edge on source 7 (bit 24) in the same cycle as its clear
    cfg_wr(4'h5, '1);
    irq_src = 32'h0000_0080;
    settle(2);
    reg_wr(4'h0, 32'h0100_0000);
    e_pend &= ~32'h0100_0000;
    model_src(32'h0000_0080);
    settle(3);
    reg_rd(4'h0, d); chk(d, 32'h0100_0000, "R5 set beats clear same cycle");
    cfg_wr(4'h0, 32'h0100_0000);
    settle(2);
    reg_rd(4'h0, d); chk(d, '0, "R5 write-one clears");

    // R10: pending appears at the third edge after an input change
    irq_src = 32'h0000_0100;
    model_src(32'h0000_0100);
    reg_rd(4'h0, d);
    settle(1);
    reg_rd(4'h0, d); chk(d, '0, "R10 not yet pending at second edge");
    reg_rd(4'h0, d); chk(d, 32'h0080_0000, "R10 pending after third edge");

    // randomized mix
    for (int it = 0; it < 60; it++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: begin
          cfg_wr(4'h4, $urandom);
          cfg_wr(4'h5, $urandom);
          cfg_wr(4'h2, $urandom);
          cfg_wr(4'h3, $urandom);
        end
        1: drive_src($urandom);
        2: cfg_wr(4'h0, $urandom);
        default: drive_src(cur ^ (32'h1 << ($urandom % 32)));
      endcase
      check_all($sformatf("random step %0d", it));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule